// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Threshold Interrupts

This block sits between the register side of an SPI controller and its shift engine. It holds two byte queues. Software fills the transmit queue by writing bytes and empties the receive queue by reading bytes. The shift engine takes transmit bytes from one stream port and delivers received bytes on another. Each queue has a trigger level that software programs. The block compares each occupancy count with its level and turns the results, together with a receive overflow event and a transfer-complete pulse from the shift engine, into four status flags. An enable mask gates the flags onto a single interrupt line.

The register side uses word addresses on `reg_addr`. Address 0 is the transmit data port (write only). Address 1 is the receive data port, and a read there pops one byte. Address 2 is the FIFO control word. Address 3 is the FIFO status word (read only). Address 4 is the interrupt status word, which is write-1-to-clear. Address 5 is the interrupt enable word. `reg_rdata` follows `reg_addr` combinationally.

The transmit stream is valid/ready. `tx_valid` is high while the transmit queue holds a byte, and `tx_data` is the oldest byte. A byte leaves the queue on a rising clock edge at which both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, `tx_data` holds its value. The receive stream has `rx_valid` only and no back-pressure, because a shift engine cannot pause a byte that has already arrived. If the queue is full, the byte is dropped and the overflow flag records the loss.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. `tx_valid` is high exactly while the transmit queue is non-empty. A transmit byte is consumed on a clock edge with `tx_valid` and `tx_ready` both high, and `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low.
- R2: The FIFO status word (address 3) carries the receive entry count in bits [7:0] and the transmit entry count in bits [23:16]. All other bits read 0.
- R3: When `rx_valid` arrives while the receive queue holds DEPTH bytes, the byte is dropped and the count stays at DEPTH. One cycle later, overflow status bit 8 is set.
- R4: A write to the transmit data port while the transmit queue is full is ignored: the count stays at DEPTH and the queued bytes are unchanged.
- R5: Status bit 0 (receive ready) is set one cycle after the receive count is greater than or equal to the receive level in FIFO control bits [7:0].
- R6: Status bit 4 (transmit request) is set one cycle after the transmit count is less than or equal to the transmit level in FIFO control bits [23:16].
- R7: Writing 1 to a status bit clears only that bit, and writing all ones clears every flag. A level flag (bit 0 or 4) that is cleared while its condition still holds reads 0 in the following cycle and 1 again one cycle after that.
- R8: A one-cycle pulse on `xfer_done` sets status bit 12 (transfer complete) on the next clock edge. An event flag (bit 8 or 12) stays set until it is cleared, and an event in the same cycle as a clear wins.
- R9: Writing 1 to FIFO control bit 15 empties the receive queue, and writing 1 to bit 31 empties the transmit queue. Both bits read back 0, and the level fields written in the same word are kept. A flush wins over a push in the same cycle.
- R10: The enable word (address 5) stores bits 0, 4, 8 and 12 and reads 0 in all other bits. `irq` is high exactly when some status bit is set together with its enable bit.
- R11: After reset, both queues are empty, both levels are 0, the enable word is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops a byte at address 1) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_valid | output | 1 | Transmit byte available to the shift engine |
| tx_ready | input | 1 | Shift engine takes the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Received byte pushed by the shift engine |
| rx_data | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse from the shift engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 8, so that both queues can be filled, overfilled and drained in a few dozen cycles. At that depth the full-queue drop, the overflow event and trigger levels equal to the depth are all reached. Trigger levels of 0 and of DEPTH-1 are also exercised. Counts up to 128 still fit the 8-bit status fields, so the depth does not change the field layout.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int          ADDR_W     = 3;
  localparam logic [2:0]  ADDR_TXD   = 3'd0;
  localparam logic [2:0]  ADDR_RXD   = 3'd1;
  localparam logic [2:0]  ADDR_FCTRL = 3'd2;
  localparam logic [2:0]  ADDR_FSTAT = 3'd3;
  localparam logic [2:0]  ADDR_ISTAT = 3'd4;
  localparam logic [2:0]  ADDR_IEN   = 3'd5;

  // flag index i lives at word bit 4*i
  localparam int NFLAG    = 4;
  localparam int FL_RXRDY = 0;
  localparam int FL_TXREQ = 1;
  localparam int FL_OVF   = 2;
  localparam int FL_DONE  = 3;

  localparam int RX_FLUSH_BIT = 15;
  localparam int TX_FLUSH_BIT = 31;

  function automatic logic [31:0] flags_to_word(input logic [NFLAG-1:0] f);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < NFLAG; i++) w[4*i] = f[i];
    return w;
  endfunction

  function automatic logic [NFLAG-1:0] word_to_flags(input logic [31:0] w);
    logic [NFLAG-1:0] f;
    for (int i = 0; i < NFLAG; i++) f[i] = w[4*i];
    return f;
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int         NF         = 4,
  parameter logic [3:0] LEVEL_MASK = 4'b0011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] cond,
  input  logic [NF-1:0] clr,
  input  logic          en_we,
  input  logic [NF-1:0] en_val,
  output logic [NF-1:0] stat,
  output logic [NF-1:0] en,
  output logic          irq
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    if (LEVEL_MASK[i]) begin : g_level
      // clear wins; a persisting condition sets the flag again next cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat[i] <= 1'b0;
        else if (clr[i])  stat[i] <= 1'b0;
        else if (cond[i]) stat[i] <= 1'b1;
      end
    end else begin : g_event
      // event wins so no occurrence is lost
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat[i] <= 1'b0;
        else if (cond[i]) stat[i] <= 1'b1;
        else if (clr[i])  stat[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= en_val;
  end

  assign irq = |(stat & en);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        xfer_done,
  output logic        irq
);

  logic [7:0]       rx_lvl, tx_lvl;
  logic             fctrl_we, rx_flush, tx_flush;
  logic             tx_push, tx_pop, rx_pop;
  logic [7:0]       tx_head, rx_head;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [7:0]       tx_cnt8, rx_cnt8;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [NFLAG-1:0] cond, clr, istat, ien;

  assign fctrl_we = reg_wr && (reg_addr == ADDR_FCTRL);
  assign rx_flush = fctrl_we && reg_wdata[RX_FLUSH_BIT];
  assign tx_flush = fctrl_we && reg_wdata[TX_FLUSH_BIT];
  assign tx_push  = reg_wr && (reg_addr == ADDR_TXD);
  assign rx_pop   = reg_rd && (reg_addr == ADDR_RXD);
  assign tx_pop   = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lvl <= '0;
      tx_lvl <= '0;
    end else if (fctrl_we) begin
      rx_lvl <= reg_wdata[7:0];
      tx_lvl <= reg_wdata[23:16];
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .push_data(reg_wdata[7:0]), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_valid), .push_data(rx_data), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign tx_data  = tx_head;
  assign tx_cnt8  = 8'(tx_cnt);
  assign rx_cnt8  = 8'(rx_cnt);

  always_comb begin
    cond           = '0;
    cond[FL_RXRDY] = (rx_cnt8 >= rx_lvl);
    cond[FL_TXREQ] = (tx_cnt8 <= tx_lvl);
    cond[FL_OVF]   = rx_valid && rx_full && !rx_flush;
    cond[FL_DONE]  = xfer_done;
  end

  assign clr = (reg_wr && (reg_addr == ADDR_ISTAT)) ? word_to_flags(reg_wdata) : '0;

  spi_irq_ctrl #(.NF(NFLAG), .LEVEL_MASK(4'b0011)) u_irq (
    .clk(clk), .rst_n(rst_n), .cond(cond), .clr(clr),
    .en_we(reg_wr && (reg_addr == ADDR_IEN)), .en_val(word_to_flags(reg_wdata)),
    .stat(istat), .en(ien), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_RXD:   reg_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
      ADDR_FCTRL: reg_rdata = {8'h0, tx_lvl, 8'h0, rx_lvl};
      ADDR_FSTAT: reg_rdata = {8'h0, tx_cnt8, 8'h0, rx_cnt8};
      ADDR_ISTAT: reg_rdata = flags_to_word(istat);
      ADDR_IEN:   reg_rdata = flags_to_word(ien);
      default:    reg_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    reg_addr,
  input logic          reg_wr,
  input logic [31:0]   reg_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_full,
  input logic          tx_flush,
  input logic          rx_valid,
  input logic          rx_full,
  input logic          rx_flush,
  input logic [CW-1:0] rx_cnt,
  input logic          xfer_done,
  input logic [3:0]    istat,
  input logic          irq
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rx_flush) |=> istat[2]);

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !(tx_valid && tx_ready) && !tx_flush) |=> tx_full);

  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_flush) |=> (tx_valid && $stable(tx_data)));

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> istat[3]);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && reg_wdata[31]) |=> !tx_valid);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (istat != 4'b0));

endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_full(tx_full), .tx_flush(tx_flush),
  .rx_valid(rx_valid), .rx_full(rx_full), .rx_flush(rx_flush),
  .rx_cnt(rx_cnt), .xfer_done(xfer_done), .istat(istat), .irq(irq)
);

// File: tb/spi_fifo_pair_tb.sv
module spi_fifo_pair_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_FCTRL = 3'd2,
                         A_FSTAT = 3'd3, A_ISTAT = 3'd4, A_IEN = 3'd5;

  // {ntx, nrx, rx level, tx level, expected {txreq, rxrdy}}
  localparam int NVEC = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd0, 8'd0, 8'd4, 8'd2, 8'b10},
    {8'd3, 8'd4, 8'd4, 8'd2, 8'b01},
    {8'd2, 8'd3, 8'd4, 8'd2, 8'b10},
    {8'd8, 8'd8, 8'd8, 8'd7, 8'b01},
    {8'd5, 8'd0, 8'd0, 8'd5, 8'b11},
    {8'd7, 8'd7, 8'd6, 8'd6, 8'b01}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        xfer_done = 1'b0, irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_pair #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .xfer_done(xfer_done), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rx_push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = base + 8'(i);
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] d);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 d = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    check("R11 irq", {31'b0, irq}, 32'h0);
    check("R11 tx_valid", {31'b0, tx_valid}, 32'h0);
    rd(A_FSTAT, v); check("R11 counts", v, 32'h0);
    rd(A_FCTRL, v); check("R11 levels", v, 32'h0);
    rd(A_IEN, v);   check("R11 enable", v, 32'h0);

    // table: R2 R5 R6 R10
    wr(A_IEN, 32'h0000_0011);
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] ntx, nrx, rxl, txl, ef;
      {ntx, nrx, rxl, txl, ef} = VEC[k];
      wr(A_FCTRL, {8'h80, txl, 8'h80, rxl});
      for (int i = 0; i < int'(ntx); i++) wr(A_TXD, 32'h40 + i);
      rx_push(int'(nrx), 8'h20);
      wr(A_ISTAT, 32'hFFFF_FFFF);
      rd(A_ISTAT, v);
      check($sformatf("R5 R6 vec%0d flags", k), v, {27'b0, ef[1], 3'b0, ef[0]});
      check($sformatf("R10 vec%0d irq", k), {31'b0, irq}, {31'b0, |ef[1:0]});
      rd(A_FSTAT, v);
      check($sformatf("R2 vec%0d counts", k), v, {8'h0, ntx, 8'h0, nrx});
    end
    wr(A_IEN, 32'h0);

    // R1 ordering on both queues
    wr(A_FCTRL, 32'h8000_8000);
    wr(A_TXD, 32'hA1); wr(A_TXD, 32'hA2); wr(A_TXD, 32'hA3);
    check("R1 tx_valid nonempty", {31'b0, tx_valid}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      tx_take(b); check("R1 tx order", {24'b0, b}, 32'hA1 + i);
    end
    check("R1 tx_valid empty", {31'b0, tx_valid}, 32'h0);
    rx_push(3, 8'h51);
    for (int i = 0; i < 3; i++) begin
      rd(A_RXD, v); check("R1 rx order", v, 32'h51 + i);
    end

    // R4 write to full transmit queue ignored
    for (int i = 0; i <= DEPTH; i++) wr(A_TXD, 32'h60 + i);
    rd(A_FSTAT, v); check("R4 tx count at full", v[23:16], DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      tx_take(b); check("R4 tx kept bytes", {24'b0, b}, 32'h60 + i);
    end
    check("R4 extra byte absent", {31'b0, tx_valid}, 32'h0);

    // R3 receive overflow
    wr(A_FCTRL, 32'h8000_8000);
    wr(A_ISTAT, 32'hFFFF_FFFF);
    rx_push(DEPTH + 1, 8'h70);
    rd(A_ISTAT, v); check("R3 overflow flag", {31'b0, v[8]}, 32'h1);
    rd(A_FSTAT, v); check("R3 count held", v[7:0], DEPTH);
    for (int i = 0; i < DEPTH; i++) rd(A_RXD, v);
    check("R3 last kept byte", v, 32'h70 + DEPTH - 1);
    rd(A_FSTAT, v); check("R3 drained", v, 32'h0);

    // R7 selective clear and level re-assert (rx level 0 holds)
    wr(A_ISTAT, 32'h0000_0001);
    peek(A_ISTAT, v);
    check("R7 bit0 cleared", {31'b0, v[0]}, 32'h0);
    check("R7 bit8 untouched", {31'b0, v[8]}, 32'h1);
    @(negedge clk); peek(A_ISTAT, v);
    check("R7 bit0 re-asserted", {31'b0, v[0]}, 32'h1);
    wr(A_ISTAT, 32'h0000_0100);
    rd(A_ISTAT, v); check("R7 overflow cleared", {31'b0, v[8]}, 32'h0);

    // R8 transfer complete and its interrupt
    wr(A_IEN, 32'h0000_1000);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    rd(A_ISTAT, v); check("R8 done flag", {31'b0, v[12]}, 32'h1);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(A_ISTAT, 32'h0000_1000);
    rd(A_ISTAT, v); check("R8 done cleared", {31'b0, v[12]}, 32'h0);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R9 flush with level update
    wr(A_TXD, 32'h11); rx_push(2, 8'h33);
    wr(A_FCTRL, 32'h8003_8005);
    rd(A_FCTRL, v); check("R9 levels kept, flush bits 0", v, 32'h0003_0005);
    rd(A_FSTAT, v); check("R9 both emptied", v, 32'h0);

    // R10 enable readback
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, v); check("R10 enable bits", v, 32'h0000_1111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule